// File: doc/BRIEF.md
# Programmable Baud Divisor Generator

This block divides the input clock by a programmable 16-bit value to produce a one-cycle clock enable at sixteen times the wanted baud rate. The divisor therefore equals the input clock frequency divided by (16 × baud). The divisor is stored as two byte-wide latches, a low byte and a high byte. Writing either latch reloads the running counter at once, so a new rate takes effect from that write and not from the end of the previous count.

The latches share the two lowest register addresses with the neighbouring UART's data and interrupt-enable registers. A divisor-access select input, normally bit 7 of the line-control register, decides which set those addresses reach. When the select is low, the block does not touch the divisor. Instead it passes the write on as a strobe to the data or interrupt-enable register, and it returns that register's read value.

Top module: `baud_divgen`

## Requirements
- R1: After reset both divisor latches read as 0 and the enable output is low.
- R2: With the access select at 1, a write to address 0 loads the low divisor byte and a write to address 1 loads the high byte. A read returns the addressed byte on `rd_data` in the same cycle.
- R3: With the access select at 0, a write to address 0 raises only `dat_wr`, and a write to address 1 raises only `ier_wr`, each in the same cycle as the write. Neither write changes the divisor. A read returns `dat_rd` for address 0 and `ier_rd` for address 1.
- R4: For a divisor D of 2 or more, the enable is a single-cycle pulse that repeats exactly every D clock cycles.
- R5: With a divisor of 1, the enable is high on every clock cycle.
- R6: With a divisor of 0, the enable stays low.
- R7: A write to either latch restarts the count. The first enable after that write comes D cycles after the write's clock edge, where D is the new 16-bit divisor, and any count in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_access | input | 1 | Divisor access select (1 = addresses 0/1 reach the divisor latches) |
| reg_addr | input | 1 | Register address, 0 or 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register (combinational) |
| dat_wr | output | 1 | Write strobe to the data register |
| ier_wr | output | 1 | Write strobe to the interrupt-enable register |
| dat_rd | input | 8 | Read value of the data register |
| ier_rd | input | 8 | Read value of the interrupt-enable register |
| baud_en | output | 1 | Clock enable at 16 × baud |

## Verification
The steering outputs `dat_wr`, `ier_wr` and `rd_data` are combinational, so the bench samples them in the write cycle itself, before the clock edge. A latch value becomes visible on `rd_data` from the cycle after the write edge. After a write edge the counter holds D, and `baud_en` rises in the D-th cycle counted from that edge, then again every D cycles. The bench samples `baud_en` on each falling edge starting from the first one after the write and compares it with the expected value for every cycle over two full periods. It runs this over a sweep of divisors from 0 to 40 plus several multi-byte values, and it adds a rewrite in the middle of a count.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DIV_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEL_DAT = 2'd0,
    SEL_IER = 2'd1,
    SEL_DLO = 2'd2,
    SEL_DHI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/baud_reg_steer.sv
module baud_reg_steer
  import baud_pkg::*;
#(
  parameter int unsigned BW = BYTE_W
) (
  input  logic          div_access,
  input  logic          reg_addr,
  input  logic          reg_wr,
  input  logic [BW-1:0] lo_q,
  input  logic [BW-1:0] hi_q,
  input  logic [BW-1:0] dat_rd,
  input  logic [BW-1:0] ier_rd,
  output logic          lo_wr,
  output logic          hi_wr,
  output logic          dat_wr,
  output logic          ier_wr,
  output logic [BW-1:0] rd_data
);
  reg_sel_e sel;

  always_comb begin
    sel = reg_sel_e'({div_access, reg_addr});
  end

  always_comb begin
    lo_wr  = 1'b0;
    hi_wr  = 1'b0;
    dat_wr = 1'b0;
    ier_wr = 1'b0;
    unique case (sel)
      SEL_DAT: begin dat_wr = reg_wr; rd_data = dat_rd; end
      SEL_IER: begin ier_wr = reg_wr; rd_data = ier_rd; end
      SEL_DLO: begin lo_wr  = reg_wr; rd_data = lo_q;   end
      default: begin hi_wr  = reg_wr; rd_data = hi_q;   end
    endcase
  end
endmodule

// File: rtl/baud_div_latch.sv
module baud_div_latch
  import baud_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo_q,
  output logic [BW-1:0] hi_q,
  output logic [DW-1:0] div_q,
  output logic          load,
  output logic [DW-1:0] load_val
);
  logic [BW-1:0] lo_d, hi_d;

  always_comb begin
    lo_d     = lo_wr ? wdata : lo_q;
    hi_d     = hi_wr ? wdata : hi_q;
    load     = lo_wr | hi_wr;
    load_val = {hi_d, lo_d};
    div_q    = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] div_q,
  output logic          tick
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    tick   = (div_q != '0) && (cnt_q == ONE);
    cnt_en = load || (cnt_q != '0);
    if (load)
      cnt_d = load_val;
    else if (cnt_q == ONE)
      cnt_d = div_q;
    else
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/baud_divgen.sv
module baud_divgen
  import baud_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_access,
  input  logic          reg_addr,
  input  logic          reg_wr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] rd_data,
  output logic          dat_wr,
  output logic          ier_wr,
  input  logic [BW-1:0] dat_rd,
  input  logic [BW-1:0] ier_rd,
  output logic          baud_en
);
  logic          rst_meta_n, rst_q_n;
  logic          lo_wr, hi_wr, load;
  logic [BW-1:0] lo_q, hi_q;
  logic [DW-1:0] div_q, load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  baud_reg_steer #(.BW(BW)) u_steer (
    .div_access (div_access),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .lo_q       (lo_q),
    .hi_q       (hi_q),
    .dat_rd     (dat_rd),
    .ier_rd     (ier_rd),
    .lo_wr      (lo_wr),
    .hi_wr      (hi_wr),
    .dat_wr     (dat_wr),
    .ier_wr     (ier_wr),
    .rd_data    (rd_data)
  );

  baud_div_latch #(.BW(BW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .lo_wr    (lo_wr),
    .hi_wr    (hi_wr),
    .wdata    (reg_wdata),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .div_q    (div_q),
    .load     (load),
    .load_val (load_val)
  );

  baud_counter #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (load),
    .load_val (load_val),
    .div_q    (div_q),
    .tick     (baud_en)
  );
endmodule

// File: rtl/baud_divgen_chk.sv
module baud_divgen_chk #(
  parameter int unsigned BW = 8,
  localparam int unsigned DW = 2 * BW
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          div_access,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [BW-1:0] reg_wdata,
  input logic          dat_wr,
  input logic          ier_wr,
  input logic          load,
  input logic [BW-1:0] lo_q,
  input logic [BW-1:0] hi_q,
  input logic [DW-1:0] div_q,
  input logic          baud_en
);
  // R2
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && div_access && !reg_addr) |=> (lo_q == $past(reg_wdata)));

  // R2
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && div_access && reg_addr) |=> (hi_q == $past(reg_wdata)));

  // R3
  shared_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && !div_access) |=> (div_q == $past(div_q)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({dat_wr, ier_wr, load}));

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (div_q == '0) |-> !baud_en);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (baud_en && (div_q > DW'(1)) && !load) |=> !baud_en);

  // R5
  every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((div_q == DW'(1)) && $past(div_q == DW'(1)) && !$past(load)) |-> baud_en);
endmodule

bind baud_divgen baud_divgen_chk #(.BW(BW)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .div_access (div_access),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .dat_wr     (dat_wr),
  .ier_wr     (ier_wr),
  .load       (load),
  .lo_q       (lo_q),
  .hi_q       (hi_q),
  .div_q      (div_q),
  .baud_en    (baud_en)
);

// File: tb/baud_divgen_tb.sv
module baud_divgen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_access, reg_addr, reg_wr;
  logic [7:0] reg_wdata, rd_data, dat_rd, ier_rd;
  logic       dat_wr, ier_wr, baud_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_divgen u_dut (
    .clk(clk), .rst_n(rst_n), .div_access(div_access), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .dat_wr(dat_wr), .ier_wr(ier_wr), .dat_rd(dat_rd), .ier_rd(ier_rd),
    .baud_en(baud_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, returns at the negedge after the write edge
  task automatic wr(input bit acc, input bit a, input logic [7:0] d);
    div_access = acc; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit acc, input bit a, output logic [7:0] d);
    div_access = acc; reg_addr = a; #1; d = rd_data;
  endtask

  // sample baud_en for n cycles after a write edge; cycle 1 is the current negedge
  task automatic watch(input int d, input int n, input string req);
    int bad = 0, first_bad = 0, act = 0, exp = 0;
    for (int i = 1; i <= n; i++) begin
      bit e;
      if (i > 1) @(negedge clk);
      e = (d == 0) ? 1'b0 : (d == 1) ? 1'b1 : ((i % d) == 0);
      if (baud_en !== e && bad == 0) begin first_bad = i; act = baud_en; exp = e; end
      if (baud_en !== e) bad++;
    end
    check(bad == 0, req, act, exp);
    if (bad != 0) $display("  divisor=%0d first mismatch at cycle %0d", d, first_bad);
  endtask

  task automatic run_div(input int d);
    wr(1'b1, 1'b1, 8'(d >> 8));
    wr(1'b1, 1'b0, 8'(d));
    if (d == 0)      watch(d, 300, "R6");
    else if (d == 1) watch(d, 16, "R5");
    else             watch(d, 2 * d, "R4");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; div_access = 1'b0; reg_addr = 1'b0; reg_wr = 1'b0;
    reg_wdata = '0; dat_rd = 8'h5A; ier_rd = 8'hC3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b1, 1'b0, v); check(v == 0, "R1", v, 0);
    rd(1'b1, 1'b1, v); check(v == 0, "R1", v, 0);
    check(baud_en == 1'b0, "R1", baud_en, 0);

    // R2 latch write and read back
    wr(1'b1, 1'b0, 8'hA7);
    wr(1'b1, 1'b1, 8'h3C);
    rd(1'b1, 1'b0, v); check(v == 8'hA7, "R2", v, 8'hA7);
    rd(1'b1, 1'b1, v); check(v == 8'h3C, "R2", v, 8'h3C);

    // R3 shared addresses with access select low
    div_access = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h11; reg_wr = 1'b1; #1;
    check(dat_wr && !ier_wr, "R3", {dat_wr, ier_wr}, 2);
    @(posedge clk); @(negedge clk);
    reg_addr = 1'b1; reg_wdata = 8'h22; #1;
    check(ier_wr && !dat_wr, "R3", {dat_wr, ier_wr}, 1);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    rd(1'b0, 1'b0, v); check(v == 8'h5A, "R3", v, 8'h5A);
    rd(1'b0, 1'b1, v); check(v == 8'hC3, "R3", v, 8'hC3);
    rd(1'b1, 1'b0, v); check(v == 8'hA7, "R3", v, 8'hA7);
    rd(1'b1, 1'b1, v); check(v == 8'h3C, "R3", v, 8'h3C);
    @(negedge clk);

    // R4 R5 R6 sweep
    for (int d = 0; d <= 40; d++) run_div(d);
    run_div(255);
    run_div(256);
    run_div(257);
    run_div(1000);
    run_div(4096);
    run_div(0);

    // R7 rewrite in the middle of a count
    run_div(10);
    repeat (4) @(negedge clk);
    wr(1'b1, 1'b0, 8'd7);
    watch(7, 14, "R7");
    // R7 high-byte write alone reloads with the combined value
    wr(1'b1, 1'b0, 8'd5);
    repeat (2) @(negedge clk);
    wr(1'b1, 1'b1, 8'd1);
    watch(261, 522, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule